// File: doc/BRIEF.md
# Byte-Sequence Feature Unlock Detector

This block holds a single enable bit that gates a set of extended features. The bit changes only when a particular run of bytes arrives. The run is written, one byte per strobe, into the address register of the display controller. At reset the bit is cleared, so the extra features stay hidden.

Before any comparison starts, the detector has to lock on to the byte stream. It does this when it sees a nonzero byte followed straight away by a zero byte. After that it checks each new byte against a fixed table of fifteen codes.

- If all fifteen codes arrive, the bit is set and the features are open.
- If the first fourteen codes arrive and then any other byte follows, the bit is cleared and the features are closed again.
- Any other mismatch sends the detector back to look for a new sync pair. The enable bit does not change.

The strobe input must already be qualified by the bus address decode. Only writes that land on the controller's address register may raise it. Cycles with the strobe low have no effect.

Top module: `byte_lock_guard`

## Requirements
- R1: While reset is asserted and right after it is released, `unlocked` is 0.
- R2: A sync pair (a nonzero byte, then the byte 0x00) followed by the fifteen codes FF 77 B3 51 A8 D4 62 39 9C 46 2B 15 8A CD EE, in that order, sets `unlocked` to 1. The output changes on the clock edge that accepts the final EE, and not before.
- R3: After a sync pair, the first fourteen codes (FF through CD) followed by any byte other than EE clear `unlocked` to 0.
- R4: Without a valid sync pair, the code run has no effect. This covers a 0x00 that is not preceded by a nonzero byte since the last reset or resync.
- R5: A byte that fails to match at any of positions 1 to 14 leaves `unlocked` at its current value. The detector then goes back to hunting for sync.
- R6: A nonzero mismatching byte counts as the first half of a new sync pair. A 0x00 written straight after it starts a new match.
- R7: A mismatching 0x00 does not start a sync pair. A later code run needs a fresh nonzero-then-zero pair.
- R8: The terminating byte that relocks (R3) counts as the first half of a new sync pair when it is nonzero.
- R9: Cycles with `wr_en` low do not advance, reset or disturb the detector, whatever `wr_data` holds.
- R10: After a completed unlock, the final EE counts as the first half of a sync pair. When the relocking byte of R3 is 0x00, it does not arm sync.
- R11: Running the full sequence while already unlocked keeps `unlocked` at 1. Running the relock form while already locked keeps it at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe: a write to the display controller address register is accepted this cycle |
| wr_data | input | 8 | Byte carried by the write |
| unlocked | output | 1 | Extended features are enabled |

## Verification
The case that is hardest to reach from the ports is the one where the matcher leaves a partial or finished run already armed for the next sync. The pins show nothing of this state. It can only be seen through what the next zero byte does.

The stimulus gets there in a few ways:
- It ends runs with chosen nonzero bytes, with zero bytes and with the final EE.
- It then sends a bare 0x00 and a full code run, or the relock form.
- It checks whether the flag changes.

Idle cycles that carry stray zero and nonzero data are mixed into one run. This shows that only strobed bytes move the matcher.

// File: rtl/lk_pkg.sv
package lk_pkg;

   localparam int unsigned LK_BYTE_W  = 8;
   localparam int unsigned LK_SEQ_LEN = 15;

   typedef enum logic [1:0] {
      LK_HUNT  = 2'd0,
      LK_ARMED = 2'd1,
      LK_MATCH = 2'd2
   } lk_state_e;

   // Expected code for each position of the unlock run.
   function automatic logic [LK_BYTE_W-1:0] lk_code(input int unsigned pos);
      logic [LK_BYTE_W-1:0] v;
      case (pos)
         0:       v = 8'hFF;
         1:       v = 8'h77;
         2:       v = 8'hB3;
         3:       v = 8'h51;
         4:       v = 8'hA8;
         5:       v = 8'hD4;
         6:       v = 8'h62;
         7:       v = 8'h39;
         8:       v = 8'h9C;
         9:       v = 8'h46;
         10:      v = 8'h2B;
         11:      v = 8'h15;
         12:      v = 8'h8A;
         13:      v = 8'hCD;
         14:      v = 8'hEE;
         default: v = 8'h00;
      endcase
      return v;
   endfunction

endpackage

// File: rtl/lk_byte_cmp.sv
module lk_byte_cmp
   import lk_pkg::*;
#(
   parameter int unsigned DATA_W       = 8,
   parameter int unsigned SEQ_LEN      = 15,
   parameter bit          CMP_PARALLEL = 1'b1,
   localparam int unsigned IDX_W       = $clog2(SEQ_LEN)
) (
   input  logic [DATA_W-1:0] byte_in,
   input  logic [IDX_W-1:0]  pos,
   output logic              is_zero,
   output logic              pos_hit
);

   assign is_zero = (byte_in == '0);

   generate
      if (CMP_PARALLEL) begin : g_parallel
         // One comparator per position, result picked by the position.
         logic [SEQ_LEN-1:0] hit_vec;
         for (genvar i = 0; i < SEQ_LEN; i++) begin : g_hit
            assign hit_vec[i] = (byte_in == DATA_W'(lk_code(i)));
         end
         always_comb begin
            pos_hit = 1'b0;
            for (int j = 0; j < SEQ_LEN; j++) begin
               if (pos == IDX_W'(j)) pos_hit = hit_vec[j];
            end
         end
      end else begin : g_lookup
         // Single comparator fed by a position-indexed code table.
         logic [DATA_W-1:0] want;
         always_comb begin
            want = DATA_W'(lk_code(32'(pos)));
         end
         assign pos_hit = (byte_in == want);
      end
   endgenerate

endmodule

// File: rtl/lk_seq_fsm.sv
module lk_seq_fsm
   import lk_pkg::*;
#(
   parameter int unsigned SEQ_LEN = 15,
   localparam int unsigned IDX_W  = $clog2(SEQ_LEN),
   localparam logic [IDX_W-1:0] LAST_POS = IDX_W'(SEQ_LEN - 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             is_zero,
   input  logic             pos_hit,
   output logic [IDX_W-1:0] pos,
   output logic             run_done,
   output logic             run_relock
);

   lk_state_e        st_q, st_d;
   logic [IDX_W-1:0] pos_q, pos_d;

   always_comb begin
      st_d       = st_q;
      pos_d      = pos_q;
      run_done   = 1'b0;
      run_relock = 1'b0;
      if (wr_en) begin
         unique case (st_q)
            LK_HUNT: begin
               if (!is_zero) st_d = LK_ARMED;
            end
            LK_ARMED: begin
               if (is_zero) begin
                  st_d  = LK_MATCH;
                  pos_d = '0;
               end
            end
            LK_MATCH: begin
               if (pos_hit) begin
                  if (pos_q == LAST_POS) begin
                     run_done = 1'b1;
                     st_d     = LK_ARMED;
                     pos_d    = '0;
                  end else begin
                     pos_d = pos_q + 1'b1;
                  end
               end else begin
                  run_relock = (pos_q == LAST_POS);
                  st_d       = is_zero ? LK_HUNT : LK_ARMED;
                  pos_d      = '0;
               end
            end
            default: begin
               st_d  = LK_HUNT;
               pos_d = '0;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= LK_HUNT;
         pos_q <= '0;
      end else begin
         st_q  <= st_d;
         pos_q <= pos_d;
      end
   end

   assign pos = pos_q;

endmodule

// File: rtl/lk_lock_flag.sv
module lk_lock_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag_o <= 1'b0;
      else if (set_i) flag_o <= 1'b1;
      else if (clr_i) flag_o <= 1'b0;
   end

endmodule

// File: rtl/byte_lock_guard.sv
module byte_lock_guard
   import lk_pkg::*;
#(
   parameter int unsigned DATA_W       = 8,
   parameter int unsigned SEQ_LEN      = 15,
   parameter bit          CMP_PARALLEL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              unlocked
);

   localparam int unsigned IDX_W = $clog2(SEQ_LEN);

   generate
      if (DATA_W != LK_BYTE_W) begin : g_bad_width
         $error("byte_lock_guard: DATA_W must equal the code width");
      end
      if (SEQ_LEN != LK_SEQ_LEN) begin : g_bad_len
         $error("byte_lock_guard: SEQ_LEN must equal the code table length");
      end
   endgenerate

   logic             is_zero;
   logic             pos_hit;
   logic [IDX_W-1:0] pos;
   logic             run_done;
   logic             run_relock;

   lk_byte_cmp #(
      .DATA_W      (DATA_W),
      .SEQ_LEN     (SEQ_LEN),
      .CMP_PARALLEL(CMP_PARALLEL)
   ) u_cmp (
      .byte_in(wr_data),
      .pos    (pos),
      .is_zero(is_zero),
      .pos_hit(pos_hit)
   );

   lk_seq_fsm #(
      .SEQ_LEN(SEQ_LEN)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .is_zero   (is_zero),
      .pos_hit   (pos_hit),
      .pos       (pos),
      .run_done  (run_done),
      .run_relock(run_relock)
   );

   lk_lock_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (run_done),
      .clr_i (run_relock),
      .flag_o(unlocked)
   );

endmodule

// File: rtl/byte_lock_guard_chk.sv
module byte_lock_guard_chk #(
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [DATA_W-1:0] wr_data,
   input logic              unlocked
);

   // R1: reset leaves the lock closed
   a_r1_reset_locked: assert property (@(posedge clk) !rst_n |=> !unlocked);

   // R2: opening only follows a strobed EE
   a_r2_open_on_ee: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(unlocked) |-> $past(wr_en && (wr_data == DATA_W'(8'hEE))));

   // R3: closing only follows a strobed non-EE byte
   a_r3_close_on_other: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(unlocked) |-> $past(wr_en && (wr_data != DATA_W'(8'hEE))));

   // R9: idle cycles leave the flag alone
   a_r9_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(unlocked));

endmodule

bind byte_lock_guard byte_lock_guard_chk #(.DATA_W(DATA_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .wr_data (wr_data),
   .unlocked(unlocked)
);

// File: tb/byte_lock_guard_test.sv
module byte_lock_guard_test;

   logic       clk;
   logic       rst_n;
   logic       wr_en;
   logic [7:0] wr_data;
   logic       unlocked;

   int errors = 0;
   int checks = 0;

   logic [7:0] code_tab [15] = '{8'hFF, 8'h77, 8'hB3, 8'h51, 8'hA8,
                                 8'hD4, 8'h62, 8'h39, 8'h9C, 8'h46,
                                 8'h2B, 8'h15, 8'h8A, 8'hCD, 8'hEE};

   byte_lock_guard uut (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .unlocked(unlocked)
   );

   initial clk = 1'b0;
   always #4 clk = ~clk;

   task automatic check(input string req, input logic expv);
      checks++;
      if (unlocked !== expv) begin
         errors++;
         $display("FAIL %s: unlocked=%b expected=%b", req, unlocked, expv);
      end
   endtask

   // Called at a negedge; returns at the next negedge with the byte taken.
   task automatic wr(input logic [7:0] b);
      wr_en   = 1'b1;
      wr_data = b;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic sync_pair();
      wr(8'h5A);
      wr(8'h00);
   endtask

   task automatic codes(input int n);
      for (int i = 0; i < n; i++) wr(code_tab[i]);
   endtask

   task automatic do_reset();
      rst_n   = 1'b0;
      wr_en   = 1'b0;
      wr_data = 8'h00;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_reset();
      rst_n   = 1'b0;
      wr_en   = 1'b0;
      wr_data = 8'h00;
      repeat (2) @(negedge clk);
      check("R1 during reset", 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset", 1'b0);
   endtask

   task automatic t_unlock();
      do_reset();
      sync_pair();
      codes(14);
      check("R2 not before final EE", 1'b0);
      wr(8'hEE);
      check("R2 full run opens", 1'b1);
      sync_pair();
      codes(15);
      check("R11 full run while open", 1'b1);
   endtask

   task automatic t_relock();
      do_reset();
      sync_pair();
      codes(15);
      sync_pair();
      codes(14);
      wr(8'h01);
      check("R3 prefix plus other closes", 1'b0);
      wr(8'h00);
      codes(15);
      check("R8 nonzero relock byte arms sync", 1'b1);
      do_reset();
      sync_pair();
      codes(14);
      wr(8'h33);
      check("R11 relock while closed", 1'b0);
   endtask

   task automatic t_nosync();
      do_reset();
      wr(8'h00);
      codes(15);
      check("R4 zero without prior nonzero", 1'b0);
      do_reset();
      wr(8'h00);
      wr(8'h00);
      codes(15);
      check("R4 double zero no sync", 1'b0);
   endtask

   task automatic t_mismatch();
      do_reset();
      sync_pair();
      codes(15);
      sync_pair();
      codes(5);
      wr(8'h13);
      check("R5 mismatch keeps open", 1'b1);
      do_reset();
      sync_pair();
      codes(6);
      wr(8'h00);
      check("R5 mismatch keeps closed", 1'b0);
   endtask

   task automatic t_rearm();
      do_reset();
      sync_pair();
      codes(3);
      wr(8'h42);
      wr(8'h00);
      codes(15);
      check("R6 nonzero mismatch arms sync", 1'b1);
   endtask

   task automatic t_zero_mis();
      do_reset();
      sync_pair();
      codes(2);
      wr(8'h00);
      codes(15);
      check("R7 zero mismatch does not arm", 1'b0);
   endtask

   task automatic t_idle();
      do_reset();
      wr_data = 8'h5A;
      @(negedge clk);
      wr_data = 8'h00;
      @(negedge clk);
      for (int i = 0; i < 15; i++) begin
         wr_data = code_tab[i];
         @(negedge clk);
      end
      check("R9 unstrobed run ignored", 1'b0);
      sync_pair();
      for (int i = 0; i < 15; i++) begin
         wr(code_tab[i]);
         wr_data = 8'h00;
         @(negedge clk);
         wr_data = 8'hFF;
         @(negedge clk);
      end
      check("R9 idle gaps do not disturb", 1'b1);
   endtask

   task automatic t_after_done();
      do_reset();
      sync_pair();
      codes(15);
      wr(8'h00);
      codes(14);
      wr(8'h00);
      check("R10 EE arms sync, zero relock", 1'b0);
      codes(15);
      check("R10 zero relock does not arm", 1'b0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      rst_n   = 1'b0;
      wr_en   = 1'b0;
      wr_data = 8'h00;
      @(negedge clk);
      t_reset();
      t_unlock();
      t_relock();
      t_nosync();
      t_mismatch();
      t_rearm();
      t_zero_mis();
      t_idle();
      t_after_done();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule